// File: doc/BRIEF.md
# Half-Width Feistel Encryption Core with Stored Round Keys

This core encrypts 64-bit blocks with a balanced Feistel cipher that runs for 31 rounds. Each round substitutes the upper half through eight 4-bit S-boxes and then applies two XOR-and-rotate mixes. A 32-bit input port feeds the core, so a block arrives as two words. The 31 rounds then run at two cycles each. The ciphertext appears on a 64-bit port at the end.

The 128-bit key is a build-time parameter. At elaboration, a constant function runs the key schedule and produces a table of 62 round-key words. The datapath reads this table by round number and mix phase, so no key-update logic exists at run time. The core suits low-power endpoints where one fixed key serves the whole life of the part.

Top module: `halfpath_cipher`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `ct` is all zeros, `done` is 0 and the core is idle.
- R2: When the core is idle, `ld` with `ld_hi`=1 captures `din` into `ct[63:32]` on the next clock edge and leaves `ct[31:0]` unchanged. `ld` with `ld_hi`=0 captures `din` into `ct[31:0]` and starts encryption.
- R3: One round with upper half U and lower half L works as follows. Let s be U with each nibble passed through the S-box 0..F -> 3,F,E,1,0,A,5,8,C,4,B,2,9,7,6,D. The new L is rotl3(s ^ L ^ klo). The new U is rotr7(s ^ newL ^ khi). The ciphertext is {U,L} after 31 rounds.
- R4: Round r (0..30) uses klo = K[31:0] and khi = K[63:32] of a 128-bit register K, which starts at the KEY parameter. After each round, K is updated in this order: rotate left by 13; replace nibble [3:0] and nibble [7:4] each by its S-box image; XOR bits [63:59] with r+1.
- R5: `done` is high for exactly one cycle, 62 clock edges after the edge that captured the lower word. In that cycle `ct` holds the ciphertext.
- R6: While an encryption is running, `ld` is ignored whatever the values of `ld_hi` and `din`.
- R7: Any number of idle cycles may separate the upper word and the lower word without changing the result.
- R8: While the core is idle and `ld` is low, `ct` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld | input | 1 | Load strobe for one input word |
| ld_hi | input | 1 | 1: word is the upper half; 0: word is the lower half and starts encryption |
| din | input | 32 | Plaintext word |
| ct | output | 64 | State halves {upper, lower}; ciphertext when `done` is high |
| done | output | 1 | One-cycle strobe marking a finished block |

## Verification
The bench tries several kinds of plaintext. An all-zero block shows that the round keys alone drive the diffusion. An all-ones block and a block with one bit set expose faults in the S-box and in the rotation amounts. A mixed-pattern block and two blocks that differ only in the lower half show that the two halves are not swapped or shared. Directed runs then check four things. A gap between the two input words must not change the result. Loads injected mid-run must be ignored. A reset mid-run must bring the core back to its cleared state. The latency must be exactly 62 edges, which separates an off-by-one round count from a correct one.

// File: rtl/halfpath_cipher.sv
module halfpath_cipher #(
  parameter int          ROUNDS = 31,
  parameter logic [127:0] KEY   = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic        ld_hi,
  input  logic [31:0] din,
  output logic [63:0] ct,
  output logic        done
);
  localparam int NKW = 2 * ROUNDS;
  localparam int RW  = $clog2(ROUNDS);

  function automatic logic [3:0] sb4(input logic [3:0] x);
    case (x)
      4'h0: sb4 = 4'h3; 4'h1: sb4 = 4'hf; 4'h2: sb4 = 4'he; 4'h3: sb4 = 4'h1;
      4'h4: sb4 = 4'h0; 4'h5: sb4 = 4'ha; 4'h6: sb4 = 4'h5; 4'h7: sb4 = 4'h8;
      4'h8: sb4 = 4'hc; 4'h9: sb4 = 4'h4; 4'ha: sb4 = 4'hb; 4'hb: sb4 = 4'h2;
      4'hc: sb4 = 4'h9; 4'hd: sb4 = 4'h7; 4'he: sb4 = 4'h6; default: sb4 = 4'hd;
    endcase
  endfunction

  function automatic logic [31:0] sb32(input logic [31:0] x);
    logic [31:0] y;
    for (int i = 0; i < 8; i++) y[4*i +: 4] = sb4(x[4*i +: 4]);
    return y;
  endfunction

  function automatic logic [NKW*32-1:0] build_keys(input logic [127:0] k0);
    logic [127:0]       k;
    logic [NKW*32-1:0]  t;
    k = k0;
    t = '0;
    for (int r = 0; r < ROUNDS; r++) begin
      t[(2*r)*32   +: 32] = k[31:0];
      t[(2*r+1)*32 +: 32] = k[63:32];
      k        = {k[114:0], k[127:115]};
      k[3:0]   = sb4(k[3:0]);
      k[7:4]   = sb4(k[7:4]);
      k[63:59] = k[63:59] ^ 5'(r + 1);
    end
    return t;
  endfunction

  localparam logic [NKW*32-1:0] KTAB = build_keys(KEY);

  typedef enum logic [1:0] {S_LOAD, S_MIXLO, S_MIXHI} st_t;

  st_t         st;
  logic [31:0] up, lo, sreg;
  logic [RW-1:0] rnd;
  logic        busy;
  logic [RW:0] kidx;
  logic [31:0] kw, sub, xlo, xhi, mixlo, mixhi;

  assign busy  = (st != S_LOAD);
  assign kidx  = {rnd, st == S_MIXHI};
  assign kw    = KTAB[32*int'(kidx) +: 32];
  assign sub   = sb32(up);
  assign xlo   = sub ^ lo ^ kw;
  assign xhi   = sreg ^ lo ^ kw;
  assign mixlo = {xlo[28:0], xlo[31:29]};
  assign mixhi = {xhi[6:0], xhi[31:7]};
  assign ct    = {up, lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_LOAD;
      up   <= '0;
      lo   <= '0;
      sreg <= '0;
      rnd  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_LOAD: if (ld) begin
          if (ld_hi) up <= din;
          else begin
            lo  <= din;
            rnd <= '0;
            st  <= S_MIXLO;
          end
        end
        S_MIXLO: begin
          lo   <= mixlo;
          sreg <= sub;
          st   <= S_MIXHI;
        end
        default: begin
          up <= mixhi;
          if (rnd == RW'(ROUNDS - 1)) begin
            st   <= S_LOAD;
            done <= 1'b1;
          end else begin
            rnd <= rnd + 1'b1;
            st  <= S_MIXLO;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/halfpath_cipher_chk.sv
module halfpath_cipher_chk #(
  parameter int ROUNDS = 31
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ld,
  input logic        ld_hi,
  input logic [31:0] din,
  input logic [63:0] ct,
  input logic        done,
  input logic        busy
);
  logic [15:0] cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else if (!busy && ld && !ld_hi) cyc <= '0;
    else if (busy) cyc <= cyc + 1'b1;
  end

  p_hi_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ld && ld_hi) |=> (ct[63:32] == $past(din)) && (ct[31:0] == $past(ct[31:0])));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ld && !ld_hi) |=> busy && (ct[31:0] == $past(din)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc == 16'(2 * ROUNDS)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld) |=> $stable(ct));
endmodule

bind halfpath_cipher halfpath_cipher_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld), .ld_hi(ld_hi), .din(din),
  .ct(ct), .done(done), .busy(busy)
);

// File: tb/sim_halfpath_cipher.sv
module sim_halfpath_cipher;
  localparam logic [127:0] KEY = 128'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0;
  localparam logic [3:0] SB [16] = '{4'h3, 4'hf, 4'he, 4'h1, 4'h0, 4'ha, 4'h5, 4'h8,
                                     4'hc, 4'h4, 4'hb, 4'h2, 4'h9, 4'h7, 4'h6, 4'hd};
  localparam logic [63:0] PTS [6] = '{64'h0, 64'hffff_ffff_ffff_ffff,
                                      64'h0123_4567_89ab_cdef, 64'h0000_0000_0000_0001,
                                      64'h8000_0000_0000_0000, 64'h0000_0000_0000_0002};

  logic clk = 0, rst_n = 0, ld = 0, ld_hi = 0;
  logic [31:0] din = '0;
  logic [63:0] ct;
  logic done;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  halfpath_cipher #(.KEY(KEY)) u0 (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_hi(ld_hi), .din(din), .ct(ct), .done(done)
  );

  function automatic logic [31:0] nib32(input logic [31:0] x);
    logic [31:0] y;
    for (int i = 0; i < 8; i++) y[4*i +: 4] = SB[x[4*i +: 4]];
    return y;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] pt);
    logic [127:0] k;
    logic [31:0] u, l, s, t, v;
    k = KEY; u = pt[63:32]; l = pt[31:0];
    for (int r = 0; r < 31; r++) begin
      s = nib32(u);
      t = s ^ l ^ k[31:0];
      t = {t[28:0], t[31:29]};
      v = s ^ t ^ k[63:32];
      u = {v[6:0], v[31:7]};
      l = t;
      k = {k[114:0], k[127:115]};
      k[3:0] = SB[k[3:0]];
      k[7:4] = SB[k[7:4]];
      k[63:59] = k[63:59] ^ 5'(r + 1);
    end
    return {u, l};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] pt, input int gap, input bit inject);
    int k;
    logic [63:0] exp;
    exp = model(pt);
    @(negedge clk); ld = 1; ld_hi = 1; din = pt[63:32];
    @(negedge clk); ld = 0;
    chk(ct[63:32] == pt[63:32], "R2", {32'h0, ct[63:32]}, {32'h0, pt[63:32]});
    for (int g = 0; g < gap; g++) @(negedge clk);
    chk(ct[63:32] == pt[63:32], "R7", {32'h0, ct[63:32]}, {32'h0, pt[63:32]});
    ld = 1; ld_hi = 0; din = pt[31:0];
    @(negedge clk); ld = 0;
    k = 0;
    while (!done && k < 100) begin
      @(negedge clk); k++;
      if (inject && k == 10) begin ld = 1; ld_hi = 1; din = 32'hdead_beef; end
      if (inject && k == 11) ld = 0;
      if (inject && k == 20) begin ld = 1; ld_hi = 0; din = 32'h1234_5678; end
      if (inject && k == 21) ld = 0;
    end
    chk(k == 62, "R5 latency", 64'(k), 64'd62);
    chk(ct == exp, inject ? "R6" : "R3 R4", ct, exp);
    @(negedge clk);
    chk(!done, "R5 pulse", 64'(done), 64'd0);
    for (int g = 0; g < 5; g++) @(negedge clk);
    chk(ct == exp, "R8", ct, exp);
  endtask

  initial begin
    #(4 * 200000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ct == 64'h0 && !done, "R1", ct, 64'h0);
    rst_n = 1;
    @(negedge clk);
    chk(ct == 64'h0 && !done, "R1", ct, 64'h0);

    foreach (PTS[i]) run(PTS[i], 0, 0);

    run(64'hcafe_f00d_1357_9bdf, 7, 0);
    run(64'h5a5a_a5a5_3c3c_c3c3, 0, 1);

    @(negedge clk); ld = 1; ld_hi = 1; din = 32'h7777_7777;
    @(negedge clk); ld_hi = 0; din = 32'h8888_8888;
    @(negedge clk); ld = 0;
    repeat (30) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(ct == 64'h0 && !done, "R1 mid-run", ct, 64'h0);
    rst_n = 1;
    @(negedge clk);
    run(64'h0011_2233_4455_6677, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule